// File: doc/BRIEF.md
# Programmable Tick Timer

This block is the periodic timer of a processor core. It holds a free-running count and a control word. The control word carries a two-bit mode, an interrupt-enable flag, an interrupt-pending flag and a 28-bit period. Software reads and writes either word through a small register port: one select bit, a write strobe, a 32-bit write word and a 32-bit read word.

Each cycle the block compares the count with the period. The mode then decides what the count does on a match: it holds, it returns to zero, it freezes at the period, or it keeps climbing. A match with interrupt-enable set raises the pending flag, and this happens in every mode, including the disabled one. The flag stays set until software clears it. The interrupt request is a level that follows the pending flag, gated by interrupt-enable and by a single global tick-enable input.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset, both registers read as zero and `irq` is low.
- R2: Register layout. With `reg_sel`=0 the count is selected: its bits 27:0 are the count and bits 31:28 read as zero. With `reg_sel`=1 the control word is selected: bits 31:30 are the mode (00 disabled, 01 restart on match, 10 stop on match, 11 continuous), bit 29 is interrupt-enable, bit 28 is pending, and bits 27:0 are the period. Reads are combinational. A write takes effect at the next rising edge.
- R3: In disabled mode the count does not advance. Writing the control word never changes the count.
- R4: In restart mode the count increments by one per cycle. In the cycle after the count equals the period, the count is zero.
- R5: In stop mode the count increments until it equals the period and then stays at that value. The mode field keeps reading back as stop.
- R6: In continuous mode the count increments every cycle, passes the period, and wraps from 0xFFFFFFF to 0. Going from disabled back to continuous resumes from the held count.
- R7: A write to the count loads the written bits 27:0 at the next edge in any mode, and counting continues from that value.
- R8: A match (count equal to period) in a cycle where interrupt-enable is set makes pending read 1 in the next cycle, whatever the mode and whichever register was written last. With interrupt-enable clear, a match leaves pending clear.
- R9: A control write with bit 28 = 1 leaves pending unchanged, and a write with bit 28 = 0 clears it. If a match with interrupt-enable set happens in the same cycle as the clear, pending stays 1.
- R10: `irq` is high exactly while pending, interrupt-enable and `tick_en` are all 1. Pending is set on a match even while `tick_en` is low.
- R11: A count above the period produces no match until the count wraps through zero and climbs back to the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Global gate on the interrupt request |
| reg_sel | input | 1 | Register select: 0 count, 1 control word |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write word |
| reg_rdata | output | 32 | Read word of the selected register |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume that `reg_sel`, `reg_we` and `reg_wdata` are known and steady around each rising edge, and that a write lasts exactly one cycle. They also assume reset is applied before the first checked edge. The stimulus changes inputs only on the falling clock edge and holds every write strobe for a single cycle. It begins with several reset cycles. It toggles `tick_en` freely, because no property needs it held. The count-wrap cases preload the count close to 0xFFFFFFF so that the wrap happens within a few dozen cycles.

// File: rtl/tt_pkg.sv
package tt_pkg;

    localparam int TT_DATA_W   = 32;
    localparam int TT_CNT_W    = 28;
    localparam int TT_PEND_BIT = 28;

    typedef enum logic [1:0] {
        TT_OFF     = 2'b00,
        TT_RESTART = 2'b01,
        TT_STOP    = 2'b10,
        TT_CONT    = 2'b11
    } tt_mode_e;

    typedef enum logic {
        TT_SEL_COUNT = 1'b0,
        TT_SEL_CTRL  = 1'b1
    } tt_sel_e;

    typedef struct packed {
        tt_mode_e              mode;
        logic                  ie;
        logic                  pend;
        logic [TT_CNT_W-1:0]   period;
    } tt_ctrl_t;

    // Next count value when no software write is present.
    function automatic logic [TT_CNT_W-1:0] tt_next_count(
        input tt_mode_e            m,
        input logic                hit,
        input logic [TT_CNT_W-1:0] c
    );
        logic [TT_CNT_W-1:0] inc;
        inc = c + TT_CNT_W'(1);
        unique case (m)
            TT_OFF:     return c;
            TT_RESTART: return hit ? '0 : inc;
            TT_STOP:    return hit ? c : inc;
            default:    return inc;
        endcase
    endfunction

    function automatic logic [TT_DATA_W-1:0] tt_count_word(
        input logic [TT_CNT_W-1:0] c
    );
        return {{(TT_DATA_W-TT_CNT_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/tt_match.sv
module tt_match #(
    parameter int W = 28
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] period,
    output logic         hit
);
    always_comb hit = (cnt == period);
endmodule

// File: rtl/tt_counter.sv
module tt_counter
    import tt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [TT_CNT_W-1:0] load_val,
    input  tt_mode_e            mode,
    input  logic                hit,
    output logic [TT_CNT_W-1:0] cnt_q
);
    logic [TT_CNT_W-1:0] cnt_d;

    always_comb begin
        if (load) cnt_d = load_val;
        else      cnt_d = tt_next_count(mode, hit, cnt_q);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tt_ctrl_reg.sv
module tt_ctrl_reg
    import tt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  tt_ctrl_t wr_word,
    input  logic     hit,
    output tt_ctrl_t ctrl_q
);
    logic     set_pend;
    logic     keep_pend;
    tt_ctrl_t ctrl_d;

    always_comb begin
        set_pend  = hit & ctrl_q.ie;
        keep_pend = ctrl_q.pend & (~wr | wr_word.pend);
        ctrl_d    = ctrl_q;
        if (wr) begin
            ctrl_d.mode   = wr_word.mode;
            ctrl_d.ie     = wr_word.ie;
            ctrl_d.period = wr_word.period;
        end
        ctrl_d.pend = set_pend | keep_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic                 reg_sel,
    input  logic                 reg_we,
    input  logic [TT_DATA_W-1:0] reg_wdata,
    output logic [TT_DATA_W-1:0] reg_rdata,
    output logic                 irq
);
    logic                cnt_wr;
    logic                ctrl_wr;
    logic                hit;
    logic [TT_CNT_W-1:0] cnt_q;
    tt_ctrl_t            ctrl_q;
    tt_ctrl_t            wr_word;

    always_comb begin
        cnt_wr  = reg_we & (tt_sel_e'(reg_sel) == TT_SEL_COUNT);
        ctrl_wr = reg_we & (tt_sel_e'(reg_sel) == TT_SEL_CTRL);
        wr_word = tt_ctrl_t'(reg_wdata);
    end

    tt_match #(.W(TT_CNT_W)) u_match (
        .cnt    (cnt_q),
        .period (ctrl_q.period),
        .hit    (hit)
    );

    tt_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_wr),
        .load_val (reg_wdata[TT_CNT_W-1:0]),
        .mode     (ctrl_q.mode),
        .hit      (hit),
        .cnt_q    (cnt_q)
    );

    tt_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (ctrl_wr),
        .wr_word (wr_word),
        .hit     (hit),
        .ctrl_q  (ctrl_q)
    );

    always_comb begin
        reg_rdata = (tt_sel_e'(reg_sel) == TT_SEL_CTRL) ? TT_DATA_W'(ctrl_q)
                                                       : tt_count_word(cnt_q);
        irq       = ctrl_q.pend & ctrl_q.ie & tick_en;
    end
endmodule

// File: rtl/tt_checker.sv
module tt_checker
    import tt_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                cnt_wr,
    input logic                ctrl_wr,
    input logic                wr_pend,
    input logic [TT_CNT_W-1:0] cnt_wval,
    input logic [TT_CNT_W-1:0] cnt,
    input logic [TT_CNT_W-1:0] period,
    input tt_mode_e            mode,
    input logic                ie,
    input logic                pend,
    input logic                tick_en,
    input logic                irq
);
    p_disabled_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == TT_OFF && !cnt_wr) |=> $stable(cnt));

    p_restart_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == TT_RESTART && cnt == period && !cnt_wr) |=> (cnt == '0));

    p_stop_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == TT_STOP && cnt == period && !cnt_wr) |=> $stable(cnt));

    p_cont_step_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == TT_CONT && !cnt_wr) |=> (cnt == TT_CNT_W'($past(cnt) + 1)));

    p_count_load_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == $past(cnt_wval)));

    p_match_sets_pend_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt == period && ie) |=> pend);

    p_no_pend_without_ie_r8: assert property (@(posedge clk) disable iff (rst)
        (!pend && !ie) |=> !pend);

    p_write_one_no_set_r9: assert property (@(posedge clk) disable iff (rst)
        (!pend && ctrl_wr && wr_pend && !(cnt == period && ie)) |=> !pend);

    p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
        (!tick_en || !pend) |-> !irq);
endmodule

bind tick_timer tt_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_wr   (cnt_wr),
    .ctrl_wr  (ctrl_wr),
    .wr_pend  (reg_wdata[tt_pkg::TT_PEND_BIT]),
    .cnt_wval (reg_wdata[tt_pkg::TT_CNT_W-1:0]),
    .cnt      (cnt_q),
    .period   (ctrl_q.period),
    .mode     (ctrl_q.mode),
    .ie       (ctrl_q.ie),
    .pend     (ctrl_q.pend),
    .tick_en  (tick_en),
    .irq      (irq)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tick_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    localparam logic [31:0] MASK = 32'h0FFF_FFFF;

    // Behavioural reference state
    logic [31:0] m_cnt, m_per;
    logic [1:0]  m_mode;
    logic        m_ie, m_pend;

    always @(posedge clk) begin
        logic        match, set;
        logic [31:0] nc;
        if (rst) begin
            m_cnt = 0; m_per = 0; m_mode = 0; m_ie = 0; m_pend = 0;
        end else begin
            match = (m_cnt == m_per);
            set   = match && m_ie;
            nc    = m_cnt;
            if (reg_we && !reg_sel) nc = reg_wdata & MASK;
            else if (m_mode == 2'd1) nc = match ? 32'd0 : ((m_cnt + 1) & MASK);
            else if (m_mode == 2'd2) nc = match ? m_cnt : ((m_cnt + 1) & MASK);
            else if (m_mode == 2'd3) nc = (m_cnt + 1) & MASK;
            if (reg_we && reg_sel) begin
                m_mode = reg_wdata[31:30];
                m_ie   = reg_wdata[29];
                m_per  = reg_wdata & MASK;
                m_pend = set || (m_pend && reg_wdata[28]);
            end else begin
                m_pend = set || m_pend;
            end
            m_cnt = nc;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the reference, just before the rising edge
    always @(negedge clk) begin
        #3;
        if (!rst && !done) begin
            check("R2 readback vs model", reg_rdata,
                  reg_sel ? {m_mode, m_ie, m_pend, m_per[27:0]} : (m_cnt & MASK));
            check("R10 irq vs model", {31'd0, irq}, {31'd0, m_pend & m_ie & tick_en});
        end
    end

    function automatic logic [31:0] mk(input logic [1:0] m, input logic ie,
                                       input logic pd, input logic [31:0] per);
        return {m, ie, pd, per[27:0]};
    endfunction

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_reg(input string tag, input logic sel, input logic [31:0] exp);
        reg_sel = sel;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_reg("R1 count after reset", 1'b0, 32'h0);
        expect_reg("R1 control after reset", 1'b1, 32'h0);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);

        // R3 disabled holds; control write leaves count alone
        wr(1'b0, 32'h40);
        idle(10);
        expect_reg("R3 count held while disabled", 1'b0, 32'h40);
        wr(1'b1, mk(2'b00, 1'b0, 1'b0, 0));
        expect_reg("R3 control write keeps count", 1'b0, 32'h40);

        // R6 continuous, then disable, then resume
        wr(1'b1, mk(2'b11, 1'b0, 1'b0, 32'h0FFF_FFFF));
        idle(10);
        expect_reg("R6 continuous counting", 1'b0, 32'h4A);
        wr(1'b1, mk(2'b00, 1'b0, 1'b0, 0));
        idle(5);
        expect_reg("R3 stopped after disable", 1'b0, 32'h4B);
        wr(1'b1, mk(2'b11, 1'b0, 1'b0, 32'h0FFF_FFFF));
        idle(3);
        expect_reg("R6 resume from held value", 1'b0, 32'h4E);

        // R4 restart mode with interrupt enabled
        wr(1'b1, mk(2'b00, 1'b0, 1'b0, 0));
        wr(1'b0, 32'h0);
        wr(1'b1, mk(2'b01, 1'b1, 1'b0, 5));
        idle(5);
        expect_reg("R4 count reaches period", 1'b0, 32'h5);
        idle(1);
        expect_reg("R4 count back to zero", 1'b0, 32'h0);
        expect_reg("R8 pending after match", 1'b1, mk(2'b01, 1'b1, 1'b1, 5));
        check("R10 irq raised", {31'd0, irq}, 32'd1);
        wr(1'b1, mk(2'b01, 1'b1, 1'b0, 5));
        expect_reg("R9 write zero clears pending", 1'b1, mk(2'b01, 1'b1, 1'b0, 5));
        check("R10 irq drops with pending", {31'd0, irq}, 32'd0);
        wr(1'b1, mk(2'b01, 1'b1, 1'b1, 5));
        expect_reg("R9 write one does not set pending", 1'b1, mk(2'b01, 1'b1, 1'b0, 5));

        // R5 stop mode without interrupt enable
        wr(1'b1, mk(2'b00, 1'b0, 1'b0, 0));
        wr(1'b0, 32'h0);
        wr(1'b1, mk(2'b10, 1'b0, 1'b0, 8));
        idle(8);
        expect_reg("R5 count reaches period", 1'b0, 32'h8);
        idle(4);
        expect_reg("R5 count frozen at period", 1'b0, 32'h8);
        expect_reg("R5 mode still stop, R8 no pending without ie", 1'b1, mk(2'b10, 1'b0, 1'b0, 8));

        // R8 disabled-mode match, control written last
        wr(1'b1, mk(2'b00, 1'b1, 1'b0, 8));
        idle(1);
        expect_reg("R8 pending in disabled mode", 1'b1, mk(2'b00, 1'b1, 1'b1, 8));
        wr(1'b1, mk(2'b00, 1'b1, 1'b0, 8));
        expect_reg("R9 match beats clear", 1'b1, mk(2'b00, 1'b1, 1'b1, 8));
        wr(1'b0, 32'h20);
        wr(1'b1, mk(2'b00, 1'b1, 1'b0, 8));
        expect_reg("R9 clear without match", 1'b1, mk(2'b00, 1'b1, 1'b0, 8));
        // count written last
        wr(1'b0, 32'h8);
        idle(1);
        expect_reg("R8 pending when count written last", 1'b1, mk(2'b00, 1'b1, 1'b1, 8));

        // R10 tick_en low: pending sets, irq stays low
        wr(1'b0, 32'h0);
        wr(1'b1, mk(2'b00, 1'b1, 1'b0, 8));
        tick_en = 1'b0;
        wr(1'b1, mk(2'b11, 1'b1, 1'b0, 4));
        idle(5);
        expect_reg("R10 pending set with tick_en low", 1'b1, mk(2'b11, 1'b1, 1'b1, 4));
        check("R10 irq gated by tick_en", {31'd0, irq}, 32'd0);
        tick_en = 1'b1;
        #1;
        check("R10 irq follows tick_en", {31'd0, irq}, 32'd1);

        // R11 count above period waits for wrap
        wr(1'b1, mk(2'b00, 1'b0, 1'b0, 32'h10));
        wr(1'b0, 32'h0FFF_FFF0);
        wr(1'b1, mk(2'b01, 1'b1, 1'b0, 32'h10));
        idle(10);
        expect_reg("R11 no match above period", 1'b1, mk(2'b01, 1'b1, 1'b0, 32'h10));
        idle(6);
        expect_reg("R6 count wraps to zero", 1'b0, 32'h0);
        idle(16);
        expect_reg("R11 climbs to period", 1'b0, 32'h10);
        idle(1);
        expect_reg("R11 match after wrap", 1'b1, mk(2'b01, 1'b1, 1'b1, 32'h10));

        // R7 count write while running
        wr(1'b1, mk(2'b00, 1'b0, 1'b0, 32'h10));
        wr(1'b1, mk(2'b11, 1'b0, 1'b0, 32'h0FFF_FFFF));
        idle(5);
        wr(1'b0, 32'h300);
        expect_reg("R7 count loaded", 1'b0, 32'h300);
        idle(2);
        expect_reg("R7 counting continues from load", 1'b0, 32'h302);

        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule